// File: doc/BRIEF.md
# SPI Target with Same-Frame Reply

This block is the serial control port of a power driver chip. A host selects it with an active-low chip select and clocks in one 16-bit command word per frame. The clock idles low, input bits are taken on falling clock edges, and output bits change on rising clock edges. Words travel least-significant bit first. The first byte received is a command, made of a 2-bit operation and a 6-bit address. The second byte is data. The block returns its answer inside the frame that asks for it. At chip-select fall it loads a snapshot of the sticky status, led by a global error flag. Once the command byte is complete, it appends the content of the addressed register. The decoded command takes effect only when chip select rises.

All SPI pins are synchronized into the system clock domain before their edges are detected. Status bits are set by single-cycle event inputs and stay set until the host clears them. Devices can be chained: after a device has sent its own 16 reply bits, its serial output repeats its serial input delayed by 16 clocks. A frame of 32 clocks therefore leaves the last 16 bits in each device. Frames are recognized only after the enable input has been high for a set number of system clock cycles.

Top module: `spi_reply_target`

## Requirements
- R1: The serial output enable is high only during a recognized frame. It rises after chip select falls and drops when chip select rises. Outside a frame it is 0, and it is 0 after reset.
- R2: Reply bit k (k = 0..15) is presented on the k+1-th rising clock edge. Bit 0 is also presented from chip-select fall onward. Bit 0 is the OR of all seven status bits, and bits 7:1 carry status bits 6:0 as captured at chip-select fall.
- R3: Reply bits 15:8 hold the register named by the command byte. Status address 6'h3F returns {0, status}, control address a < NCTRL returns control register a, and any other address returns 0.
- R4: In the command byte, bits 7:6 hold the operation and bits 5:0 the address. Operation 2'b01 (write) to address a < NCTRL loads the data byte (word bits 15:8) into control register a when chip select rises.
- R5: Operation 2'b10 (clear) to address 6'h3F clears each status bit whose matching data bit (bits 14:8) is 1. A status event in the same cycle keeps its bit set.
- R6: A pulse on stat_evt[i] sets status bit i. The status bit stays set until a clear command removes it.
- R7: A frame whose falling-edge count is not a nonzero multiple of 16 changes no register.
- R8: After the 16th rising edge of a frame, each rising edge outputs the input bit taken 16 falling edges earlier. For a frame of 32 clocks, the last 16 bits received form the command word.
- R9: A frame that starts before enable has been high for T_SET system cycles is ignored. The output is not enabled and no register changes.
- R10: Operations 2'b00 and 2'b11 (read) change no register. A write to an address that is neither a control register nor the status register changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Device enable; frames accepted T_SET cycles after it rises |
| sclk | input | 1 | Serial clock, idles low |
| csn | input | 1 | Chip select, active low |
| sdi | input | 1 | Serial data in, LSB first |
| stat_evt | input | 7 | Single-cycle events that set sticky status bits |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo (0 means high impedance) |
| ctrl_o | output | NCTRL*8 | Control registers, register i at bits 8i+7:8i |

## Verification
The assertions assume the SPI pins change slowly compared with the system clock. They also assume no rising and falling serial clock edge falls in the same synchronized cycle, and that chip select changes only while the serial clock is low. The bench keeps within these limits: every serial clock half period spans eight system cycles, and chip select moves only while the serial clock is low. Status events are injected only between frames, so the reply snapshot taken at chip-select fall matches the live status read later in the frame. Random frames mix all four operations, mapped and unmapped addresses, and frame lengths of 8, 15, 16, 17 and 32 clocks, with directed cases for the enable setup window and the daisy chain.

// File: rtl/spi_reply_target.sv
module spi_reply_target #(
  parameter int NCTRL     = 4,
  parameter int T_SET     = 100,
  parameter int STAT_ADDR = 63
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               sclk,
  input  logic               csn,
  input  logic               sdi,
  input  logic [6:0]         stat_evt,
  output logic               sdo,
  output logic               sdo_oe,
  output logic [NCTRL*8-1:0] ctrl_o
);
  localparam int CW = $clog2(T_SET + 1);
  localparam logic [1:0] OP_WR  = 2'b01;
  localparam logic [1:0] OP_CLR = 2'b10;

  logic [2:0] sclk_p, csn_p, sdi_p;
  logic [1:0] en_p;
  logic [CW-1:0] en_cnt;
  logic ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= 3'b000;
      csn_p  <= 3'b111;
      sdi_p  <= 3'b000;
      en_p   <= 2'b00;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      csn_p  <= {csn_p[1:0], csn};
      sdi_p  <= {sdi_p[1:0], sdi};
      en_p   <= {en_p[0], en};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   en_cnt <= '0;
    else if (!en_p[1])            en_cnt <= '0;
    else if (en_cnt != CW'(T_SET)) en_cnt <= en_cnt + 1'b1;
  end
  assign ready = en_p[1] && (en_cnt == CW'(T_SET));

  wire csn_fall  = csn_p[2] & ~csn_p[1];
  wire csn_rise  = ~csn_p[2] & csn_p[1];
  wire sclk_fall = sclk_p[2] & ~sclk_p[1];
  wire sclk_rise = ~sclk_p[2] & sclk_p[1];
  wire sdi_s     = sdi_p[1];

  logic        active, full, sdo_q;
  logic [3:0]  nfall;
  logic [4:0]  nrise;
  logic [15:0] rx, tx;
  logic [6:0]  status_q;
  logic [7:0]  ctrl_q [NCTRL];
  logic [7:0]  rd_val;

  wire [15:0] rx_n = {sdi_s, rx[15:1]};
  wire        gef  = |status_q;

  always_comb begin
    rd_val = 8'h00;
    if (rx_n[13:8] == 6'(STAT_ADDR)) rd_val = {1'b0, status_q};
    for (int i = 0; i < NCTRL; i++)
      if (rx_n[13:8] == 6'(i)) rd_val = ctrl_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      full   <= 1'b0;
      nfall  <= '0;
      nrise  <= '0;
      rx     <= '0;
      tx     <= '0;
      sdo_q  <= 1'b0;
    end else if (csn_fall && ready) begin
      active <= 1'b1;
      full   <= 1'b0;
      nfall  <= '0;
      nrise  <= '0;
      tx     <= {8'h00, status_q, gef};
      sdo_q  <= gef;
    end else if (csn_rise) begin
      active <= 1'b0;
    end else if (active) begin
      if (sclk_fall) begin
        rx    <= rx_n;
        nfall <= nfall + 1'b1;
        if (nfall == 4'd15) full <= 1'b1;
        if (nfall == 4'd7 && !full) tx[15:8] <= rd_val;
      end
      if (sclk_rise) begin
        if (nrise < 5'd16) begin
          sdo_q <= tx[nrise[3:0]];
          nrise <= nrise + 1'b1;
        end else begin
          sdo_q <= rx[0];
        end
      end
    end
  end

  wire [1:0] op     = rx[7:6];
  wire [5:0] addr   = rx[5:0];
  wire [7:0] data   = rx[15:8];
  wire       commit = csn_rise && active && ready && full && (nfall == 4'd0);
  wire       clr_fire = commit && (op == OP_CLR) && (addr == 6'(STAT_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~(clr_fire ? data[6:0] : 7'h00)) | stat_evt;
  end

  for (genvar g = 0; g < NCTRL; g++) begin : g_ctrl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q[g] <= 8'h00;
      else if (commit && op == OP_WR && addr == 6'(g)) ctrl_q[g] <= data;
    end
    assign ctrl_o[g*8 +: 8] = ctrl_q[g];
  end

  assign sdo    = sdo_q;
  assign sdo_oe = active;

  // R1: deselected (synchronized) means output released
  p_oe_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_p[1] && csn_p[2]) |-> !sdo_oe);

  // R6: a set status bit only drops on a clear command
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_fire |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R7: control registers move only on a committed frame
  p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(ctrl_o));

  // R9: no frame starts while the setup window is open
  p_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !active) |=> !active);

  // R2: reply index never runs past the frame word
  p_rise_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    nrise <= 5'd16);
endmodule

// File: tb/sim_spi_reply_target.sv
module sim_spi_reply_target;
  localparam int NCTRL = 4;
  localparam int T_SET = 50;
  localparam int HALF  = 8;

  logic clk = 0, rst_n = 0, en = 0, sclk = 0, csn = 1, sdi = 0;
  logic [6:0] stat_evt = 0;
  logic sdo, sdo_oe;
  logic [NCTRL*8-1:0] ctrl_o;

  spi_reply_target #(.NCTRL(NCTRL), .T_SET(T_SET), .STAT_ADDR(63)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .sclk(sclk), .csn(csn), .sdi(sdi),
    .stat_evt(stat_evt), .sdo(sdo), .sdo_oe(sdo_oe), .ctrl_o(ctrl_o));

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  logic [7:0] m_ctrl [NCTRL];
  logic [6:0] m_stat = 0;
  logic oe_seen;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_reply(input logic [7:0] cmd);
    logic [7:0] hi;
    hi = 8'h00;
    if (cmd[5:0] == 6'd63) hi = {1'b0, m_stat};
    else if (cmd[5:0] < 6'(NCTRL)) hi = m_ctrl[cmd[5:0]];
    return {hi, m_stat, |m_stat};
  endfunction

  function automatic logic [NCTRL*8-1:0] exp_ctrl();
    logic [NCTRL*8-1:0] v;
    for (int i = 0; i < NCTRL; i++) v[i*8 +: 8] = m_ctrl[i];
    return v;
  endfunction

  task automatic model_commit(input logic [15:0] w);
    if (w[7:6] == 2'b01 && w[5:0] < 6'(NCTRL)) m_ctrl[w[5:0]] = w[15:8];
    if (w[7:6] == 2'b10 && w[5:0] == 6'd63) m_stat = m_stat & ~w[14:8];
  endtask

  task automatic frame(input int n, input logic [31:0] din, output logic [31:0] got);
    got = 0;
    oe_seen = 0;
    @(negedge clk) csn = 0;
    repeat (HALF) @(negedge clk);
    oe_seen = sdo_oe;
    for (int k = 0; k < n; k++) begin
      sclk = 1; sdi = din[k];
      repeat (HALF) @(negedge clk);
      got[k] = sdo;
      sclk = 0;
      repeat (HALF) @(negedge clk);
    end
    csn = 1;
    repeat (10) @(negedge clk);
  endtask

  task automatic run_frame(input int n, input logic [31:0] din, input string tag);
    logic [31:0] got, expv, mask;
    logic [15:0] rep;
    rep = exp_reply(din[7:0]);
    expv = {din[15:0], rep};
    mask = (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
    frame(n, din, got);
    chk(oe_seen == 1'b1, {tag, " R1 oe in frame"}, oe_seen, 1);
    chk((got & mask) == (expv & mask), {tag, " R2 R3 R8 reply"}, got & mask, expv & mask);
    if (n > 0 && n % 16 == 0) model_commit(din[n-16 +: 16]);
    chk(ctrl_o == exp_ctrl(), {tag, " R4 R7 R10 ctrl"}, ctrl_o, exp_ctrl());
    chk(sdo_oe == 1'b0, {tag, " R1 oe released"}, sdo_oe, 0);
  endtask

  task automatic pulse_evt(input logic [6:0] e);
    @(negedge clk) stat_evt = e;
    @(negedge clk) stat_evt = 0;
    m_stat = m_stat | e;
  endtask

  function automatic logic [7:0] mk_cmd(input logic [1:0] op, input logic [5:0] a);
    return {op, a};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] got;
    void'($urandom(1234));
    for (int i = 0; i < NCTRL; i++) m_ctrl[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sdo_oe == 0, "R1 reset oe", sdo_oe, 0);
    chk(ctrl_o == 0, "R4 reset ctrl", ctrl_o, 0);

    // R9: frame right after enable is ignored
    en = 1;
    repeat (3) @(negedge clk);
    frame(16, {16'h0, 8'hAA, mk_cmd(2'b01, 6'd0)}, got);
    chk(oe_seen == 0, "R9 early frame oe", oe_seen, 0);
    chk(ctrl_o == 0, "R9 early frame ctrl", ctrl_o, 0);
    repeat (T_SET + 20) @(negedge clk);

    run_frame(16, {16'h0, 8'hA5, mk_cmd(2'b01, 6'd0)}, "R4 write0");
    run_frame(16, {16'h0, 8'h3C, mk_cmd(2'b01, 6'd3)}, "R4 write3");
    run_frame(16, {16'h0, 8'hFF, mk_cmd(2'b01, 6'd5)}, "R10 unmapped write");
    run_frame(16, {16'h0, 8'h00, mk_cmd(2'b00, 6'd5)}, "R3 R10 unmapped read");
    run_frame(16, {16'h0, 8'h77, mk_cmd(2'b11, 6'd0)}, "R10 read op11");
    pulse_evt(7'h41);
    run_frame(16, {16'h0, 8'h00, mk_cmd(2'b00, 6'd63)}, "R6 status read");
    run_frame(16, {16'h0, 8'h01, mk_cmd(2'b10, 6'd63)}, "R5 partial clear");
    run_frame(16, {16'h0, 8'h00, mk_cmd(2'b00, 6'd63)}, "R5 R6 after clear");
    run_frame(15, {17'h0, 7'h7F, mk_cmd(2'b01, 6'd1)}, "R7 short");
    run_frame(17, {15'h0, 1'b1, 8'h12, mk_cmd(2'b01, 6'd1)}, "R7 long");
    run_frame(32, {8'h5A, mk_cmd(2'b01, 6'd2), 8'hEE, mk_cmd(2'b01, 6'd1)}, "R8 daisy");

    for (int it = 0; it < 180; it++) begin
      logic [1:0] op;
      logic [5:0] a;
      logic [31:0] din;
      int n, r;
      if ($urandom_range(0, 3) == 0) pulse_evt(7'($urandom()));
      op = 2'($urandom());
      r = $urandom_range(0, 7);
      a = (r < 4) ? 6'(r) : (r < 6) ? 6'd63 : 6'($urandom());
      din = $urandom();
      din[7:0] = {op, a};
      r = $urandom_range(0, 9);
      n = (r < 7) ? 16 : (r == 7) ? 32 : (r == 8) ? 15 : ((it % 2) ? 17 : 8);
      if (n == 32) din[23:16] = {op, a};
      run_frame(n, din, "rand");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule